// File: doc/BRIEF.md
# Priority Ternary Match Table

This block is a small ternary lookup table. It holds eight entries. Each entry has an 8-bit stored key, an 8-bit care mask, an 8-bit result and a valid flag. A search key is compared against every valid entry at the same time. A bit takes part in the comparison only where the entry's care bit is 1; bits with a care bit of 0 are ignored. When more than one entry matches, the entry with the lowest index wins. The outputs give a hit flag, the winning index and that entry's result.

One write port changes a single entry per clock. A load makes the addressed entry valid and replaces its key, care mask and result. A drop makes the addressed entry invalid. The search path is combinational and reads the registered table, so a write becomes visible only after the rising edge that captures it.

Reset is active high and asynchronous. It invalidates every entry at once, so the outputs report a miss without waiting for a clock edge. Reset clears only the valid flags; the stored key, mask and result fields keep their contents.

Top module: `tmatch_table`

## Requirements
- R1: An entry hits when it is valid and, in every bit position where its care bit is 1, `srch_key` equals the stored key. Stored key bits under a 0 care bit have no effect (for example, stored key 0x93 with care 0xF0 hits search key 0x9E).
- R2: An entry with care mask 0x00 hits every search key.
- R3: When several valid entries hit, `hit_slot` and `hit_data` come from the entry with the lowest index.
- R4: On a miss, `hit`, `hit_slot` and `hit_data` are all zero.
- R5: With `wr_req`=1 and `wr_drop`=0, the entry at `wr_slot` becomes valid and takes `wr_key`, `wr_care` and `wr_data` at the rising edge. Its earlier match behaviour is gone after that edge.
- R6: With `wr_req`=1 and `wr_drop`=1, the entry at `wr_slot` becomes invalid at the rising edge, so a higher-index entry that matches becomes the winner.
- R7: The lookup is combinational from the registered table. A search in the same cycle as a write sees the table as it was before that write.
- R8: While `rst`=1, the outputs show a miss at once with no clock edge, every entry is invalidated, and write requests are ignored.
- R9: With `wr_req`=0, the table does not change, whatever `wr_drop`, `wr_slot` and the write data carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| srch_key | input | 8 | Search key |
| wr_req | input | 1 | Write request for one entry |
| wr_drop | input | 1 | 1: invalidate the entry, 0: load the entry |
| wr_slot | input | 3 | Index of the entry to write |
| wr_key | input | 8 | Key to store |
| wr_care | input | 8 | Care mask to store (1 = compare this bit) |
| wr_data | input | 8 | Result to store |
| hit | output | 1 | Some valid entry matches |
| hit_slot | output | 3 | Index of the winning entry, 0 on a miss |
| hit_data | output | 8 | Result of the winning entry, 0 on a miss |

## Verification
The lookup results are due in the same cycle as a change of `srch_key`, and the effect of a load or drop is due only after the next rising edge. The bench therefore samples each step twice: 2 ns after driving the inputs, to see the old table, and 2 ns after the following rising edge, to see the updated one. Reset is checked 1 ns after it rises, with no edge in between, which shows the miss is immediate. The expected values come from a table walked in order and from a reference model that scans the entries from index 0 upward.

// File: rtl/tmatch_pkg.sv
package tmatch_pkg;

    localparam int DEF_SLOTS = 8;
    localparam int DEF_KEY_W = 8;
    localparam int DEF_VAL_W = 8;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_DROP = 2'd2
    } wr_op_e;

endpackage

// File: rtl/tmatch_store.sv
module tmatch_store
    import tmatch_pkg::*;
#(
    parameter int SLOTS = DEF_SLOTS,
    parameter int KEY_W = DEF_KEY_W,
    parameter int VAL_W = DEF_VAL_W,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_req,
    input  logic                         wr_drop,
    input  logic [IDX_W-1:0]             wr_slot,
    input  logic [KEY_W-1:0]             wr_key,
    input  logic [KEY_W-1:0]             wr_care,
    input  logic [VAL_W-1:0]             wr_data,
    output logic [SLOTS-1:0]             valid_o,
    output logic [SLOTS-1:0][KEY_W-1:0]  key_o,
    output logic [SLOTS-1:0][KEY_W-1:0]  care_o,
    output logic [SLOTS-1:0][VAL_W-1:0]  data_o
);

    typedef struct packed {
        logic [SLOTS-1:0]            valid;
        logic [SLOTS-1:0][KEY_W-1:0] key;
        logic [SLOTS-1:0][KEY_W-1:0] care;
        logic [SLOTS-1:0][VAL_W-1:0] data;
    } table_t;

    table_t tbl_d, tbl_q;
    wr_op_e op_d;

    always_comb begin
        op_d = OP_HOLD;
        if (wr_req) begin
            op_d = wr_drop ? OP_DROP : OP_LOAD;
        end
        tbl_d = tbl_q;
        case (op_d)
            OP_LOAD: begin
                tbl_d.valid[wr_slot] = 1'b1;
                tbl_d.key[wr_slot]   = wr_key;
                tbl_d.care[wr_slot]  = wr_care;
                tbl_d.data[wr_slot]  = wr_data;
            end
            OP_DROP: begin
                tbl_d.valid[wr_slot] = 1'b0;
            end
            default: begin
            end
        endcase
    end

    // only the valid flags are reset; stored fields keep their contents
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            tbl_q.valid <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign valid_o = tbl_q.valid;
    assign key_o   = tbl_q.key;
    assign care_o  = tbl_q.care;
    assign data_o  = tbl_q.data;

    // R5
    load_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_drop) |=> valid_o[$past(wr_slot)]);

    // R6
    drop_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_drop) |=> !valid_o[$past(wr_slot)]);

    // R9
    idle_holds_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_req |=> $stable(valid_o));

endmodule

// File: rtl/tmatch_compare.sv
module tmatch_compare
    import tmatch_pkg::*;
#(
    parameter int SLOTS = DEF_SLOTS,
    parameter int KEY_W = DEF_KEY_W
) (
    input  logic [KEY_W-1:0]             srch_key,
    input  logic [SLOTS-1:0]             valid_i,
    input  logic [SLOTS-1:0][KEY_W-1:0]  key_i,
    input  logic [SLOTS-1:0][KEY_W-1:0]  care_i,
    output logic [SLOTS-1:0]             match_o
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [KEY_W-1:0] diff;
        assign diff       = (srch_key ^ key_i[g]) & care_i[g];
        assign match_o[g] = valid_i[g] && (diff == '0);
    end

endmodule

// File: rtl/tmatch_select.sv
module tmatch_select
    import tmatch_pkg::*;
#(
    parameter int SLOTS = DEF_SLOTS,
    parameter int VAL_W = DEF_VAL_W,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0]             match_i,
    input  logic [SLOTS-1:0][VAL_W-1:0]  data_i,
    output logic                         hit_o,
    output logic [IDX_W-1:0]             slot_o,
    output logic [VAL_W-1:0]             data_o
);

    // scan from the top down so the lowest matching index is assigned last
    always_comb begin
        hit_o  = 1'b0;
        slot_o = '0;
        data_o = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match_i[i]) begin
                hit_o  = 1'b1;
                slot_o = IDX_W'(i);
                data_o = data_i[i];
            end
        end
    end

endmodule

// File: rtl/tmatch_table.sv
module tmatch_table
    import tmatch_pkg::*;
#(
    parameter int SLOTS = DEF_SLOTS,
    parameter int KEY_W = DEF_KEY_W,
    parameter int VAL_W = DEF_VAL_W,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [KEY_W-1:0] srch_key,
    input  logic             wr_req,
    input  logic             wr_drop,
    input  logic [IDX_W-1:0] wr_slot,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [KEY_W-1:0] wr_care,
    input  logic [VAL_W-1:0] wr_data,
    output logic             hit,
    output logic [IDX_W-1:0] hit_slot,
    output logic [VAL_W-1:0] hit_data
);

    logic [SLOTS-1:0]            valid_q;
    logic [SLOTS-1:0][KEY_W-1:0] key_q;
    logic [SLOTS-1:0][KEY_W-1:0] care_q;
    logic [SLOTS-1:0][VAL_W-1:0] data_q;
    logic [SLOTS-1:0]            match_vec;

    tmatch_store #(.SLOTS(SLOTS), .KEY_W(KEY_W), .VAL_W(VAL_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .wr_drop (wr_drop),
        .wr_slot (wr_slot),
        .wr_key  (wr_key),
        .wr_care (wr_care),
        .wr_data (wr_data),
        .valid_o (valid_q),
        .key_o   (key_q),
        .care_o  (care_q),
        .data_o  (data_q)
    );

    tmatch_compare #(.SLOTS(SLOTS), .KEY_W(KEY_W)) u_compare (
        .srch_key (srch_key),
        .valid_i  (valid_q),
        .key_i    (key_q),
        .care_i   (care_q),
        .match_o  (match_vec)
    );

    tmatch_select #(.SLOTS(SLOTS), .VAL_W(VAL_W)) u_select (
        .match_i (match_vec),
        .data_i  (data_q),
        .hit_o   (hit),
        .slot_o  (hit_slot),
        .data_o  (hit_data)
    );

    // R3
    winner_matches_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> match_vec[hit_slot]);

    // R3
    no_lower_winner_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> ((match_vec & ((SLOTS'(1) << hit_slot) - SLOTS'(1))) == '0));

    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_slot == '0 && hit_data == '0 && match_vec == '0));

    // R8
    reset_miss_chk: assert property (@(posedge clk)
        rst |-> (!hit && valid_q == '0));

endmodule

// File: tb/tmatch_table_bench.sv
module tmatch_table_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] srch_key;
    logic       wr_req;
    logic       wr_drop;
    logic [2:0] wr_slot;
    logic [7:0] wr_key;
    logic [7:0] wr_care;
    logic [7:0] wr_data;
    logic       hit;
    logic [2:0] hit_slot;
    logic [7:0] hit_data;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    tmatch_table u_tmatch_table (
        .clk      (clk),
        .rst      (rst),
        .srch_key (srch_key),
        .wr_req   (wr_req),
        .wr_drop  (wr_drop),
        .wr_slot  (wr_slot),
        .wr_key   (wr_key),
        .wr_care  (wr_care),
        .wr_data  (wr_data),
        .hit      (hit),
        .hit_slot (hit_slot),
        .hit_data (hit_data)
    );

    typedef struct packed {
        logic        req;
        logic        drop;
        logic [2:0]  slot;
        logic [7:0]  key, care, data, srch;
        logic        pre_h;
        logic [2:0]  pre_s;
        logic [7:0]  pre_d;
        logic        post_h;
        logic [2:0]  post_s;
        logic [7:0]  post_d;
        logic [31:0] tag;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 3'd2, 8'h6C, 8'hFF, 8'h21, 8'h6C, 1'b0, 3'd0, 8'h00, 1'b1, 3'd2, 8'h21, "R7"},
        '{1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h6D, 1'b0, 3'd0, 8'h00, 1'b0, 3'd0, 8'h00, "R1"},
        '{1'b1, 1'b0, 3'd5, 8'h93, 8'hF0, 8'h42, 8'h9E, 1'b0, 3'd0, 8'h00, 1'b1, 3'd5, 8'h42, "R1"},
        '{1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'hA3, 1'b0, 3'd0, 8'h00, 1'b0, 3'd0, 8'h00, "R4"},
        '{1'b1, 1'b0, 3'd1, 8'h00, 8'h00, 8'h37, 8'hE1, 1'b0, 3'd0, 8'h00, 1'b1, 3'd1, 8'h37, "R2"},
        '{1'b1, 1'b0, 3'd0, 8'hE4, 8'hF0, 8'h58, 8'hE9, 1'b1, 3'd1, 8'h37, 1'b1, 3'd0, 8'h58, "R3"},
        '{1'b1, 1'b0, 3'd3, 8'hE0, 8'hF0, 8'h6A, 8'hEE, 1'b1, 3'd0, 8'h58, 1'b1, 3'd0, 8'h58, "R3"},
        '{1'b1, 1'b1, 3'd0, 8'h00, 8'h00, 8'h00, 8'hE2, 1'b1, 3'd0, 8'h58, 1'b1, 3'd1, 8'h37, "R6"},
        '{1'b1, 1'b0, 3'd1, 8'h12, 8'hFF, 8'h7B, 8'h12, 1'b1, 3'd1, 8'h37, 1'b1, 3'd1, 8'h7B, "R5"},
        '{1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h34, 1'b0, 3'd0, 8'h00, 1'b0, 3'd0, 8'h00, "R5"},
        '{1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'hE7, 1'b1, 3'd3, 8'h6A, 1'b1, 3'd3, 8'h6A, "R3"},
        '{1'b0, 1'b1, 3'd3, 8'hE7, 8'hFF, 8'hEE, 8'hE7, 1'b1, 3'd3, 8'h6A, 1'b1, 3'd3, 8'h6A, "R9"},
        '{1'b1, 1'b1, 3'd3, 8'h00, 8'h00, 8'h00, 8'h9F, 1'b1, 3'd5, 8'h42, 1'b1, 3'd5, 8'h42, "R6"},
        '{1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'hE7, 1'b0, 3'd0, 8'h00, 1'b0, 3'd0, 8'h00, "R6"}
    };

    logic       ref_v [8];
    logic [7:0] ref_k [8];
    logic [7:0] ref_c [8];
    logic [7:0] ref_d [8];

    task automatic chk(input string rq, input logic eh, input logic [2:0] es,
                       input logic [7:0] ed);
        total++;
        if (hit !== eh || hit_slot !== es || hit_data !== ed) begin
            bad++;
            $display("FAIL %s: got hit=%b slot=%0d data=%02h expected hit=%b slot=%0d data=%02h",
                     rq, hit, hit_slot, hit_data, eh, es, ed);
        end
    endtask

    task automatic ref_look(input logic [7:0] s, output logic h,
                            output logic [2:0] idx, output logic [7:0] d);
        h = 1'b0; idx = 3'd0; d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (!h && ref_v[i] && (((s ^ ref_k[i]) & ref_c[i]) == 8'h00)) begin
                h = 1'b1; idx = 3'(i); d = ref_d[i];
            end
        end
    endtask

    task automatic ref_write(input logic rq, input logic dr, input logic [2:0] sl,
                             input logic [7:0] k, input logic [7:0] c, input logic [7:0] d);
        if (rq) begin
            if (dr) begin
                ref_v[sl] = 1'b0;
            end else begin
                ref_v[sl] = 1'b1; ref_k[sl] = k; ref_c[sl] = c; ref_d[sl] = d;
            end
        end
    endtask

    task automatic ref_clear();
        for (int i = 0; i < 8; i++) begin
            ref_v[i] = 1'b0; ref_k[i] = 8'h00; ref_c[i] = 8'h00; ref_d[i] = 8'h00;
        end
    endtask

    task automatic drive(input logic rq, input logic dr, input logic [2:0] sl,
                         input logic [7:0] k, input logic [7:0] c, input logic [7:0] d,
                         input logic [7:0] s);
        wr_req = rq; wr_drop = dr; wr_slot = sl;
        wr_key = k; wr_care = c; wr_data = d; srch_key = s;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic       eh;
        logic [2:0] es;
        logic [7:0] ed;

        rst = 1'b1;
        drive(1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00);
        ref_clear();
        #2;
        chk("R8 reset state", 1'b0, 3'd0, 8'h00);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // vector table: pre check sees old table, post check after the edge
        for (int n = 0; n < NVEC; n++) begin
            @(negedge clk);
            drive(VECS[n].req, VECS[n].drop, VECS[n].slot, VECS[n].key,
                  VECS[n].care, VECS[n].data, VECS[n].srch);
            #2;
            chk($sformatf("%s row %0d pre", VECS[n].tag, n),
                VECS[n].pre_h, VECS[n].pre_s, VECS[n].pre_d);
            @(posedge clk);
            #2;
            chk($sformatf("%s row %0d post", VECS[n].tag, n),
                VECS[n].post_h, VECS[n].post_s, VECS[n].post_d);
        end

        // asynchronous reset mid-stream, writes ignored while it is held
        @(negedge clk);
        drive(1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h12);
        #2;
        chk("R5 slot1 before reset", 1'b1, 3'd1, 8'h7B);
        #1;
        rst = 1'b1;
        #1;
        chk("R8 immediate miss", 1'b0, 3'd0, 8'h00);
        drive(1'b1, 1'b0, 3'd4, 8'h55, 8'hFF, 8'h99, 8'h55);
        @(posedge clk);
        #2;
        chk("R8 write during reset", 1'b0, 3'd0, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h55);
        #2;
        chk("R8 write was ignored", 1'b0, 3'd0, 8'h00);
        srch_key = 8'h12;
        #2;
        chk("R8 old entry invalidated", 1'b0, 3'd0, 8'h00);
        srch_key = 8'h6C;
        #2;
        chk("R8 slot2 invalidated", 1'b0, 3'd0, 8'h00);
        ref_clear();

        // random writes, drops and searches against the reference model
        for (int n = 0; n < 400; n++) begin
            logic       rq, dr;
            logic [2:0] sl;
            logic [7:0] k, c, d, s;
            int         sel;
            rq  = ($urandom % 3) != 0;
            dr  = ($urandom % 4) == 0;
            sl  = 3'($urandom);
            k   = 8'($urandom);
            d   = 8'($urandom);
            sel = $urandom % 4;
            c   = (sel == 0) ? 8'hFF : (sel == 1) ? 8'h00 : 8'($urandom);
            s   = ($urandom % 2) ? (ref_k[3'($urandom)] ^ 8'($urandom % 4)) : 8'($urandom);
            @(negedge clk);
            drive(rq, dr, sl, k, c, d, s);
            #2;
            ref_look(s, eh, es, ed);
            chk("R7 random pre", eh, es, ed);
            ref_write(rq, dr, sl, k, c, d);
            @(posedge clk);
            #2;
            ref_look(s, eh, es, ed);
            chk("R1 random post", eh, es, ed);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule